// File: doc/BRIEF.md
# Ping-pong capture buffer controller

This block steers a continuous stream of 32-bit audio samples into two memory buffers that software hands over in turn. Software loads two base addresses and one shared size, then sets the enable bit. Filling starts at the first byte of buffer 1. When a buffer is full, its full flag is raised and the next sample goes to the first byte of the other buffer, so no sample is lost. Software answers each full flag with an acknowledge, usually after it has loaded a fresh base address for that buffer.

If a buffer completes while the other buffer's full flag is still set, a sticky overrun flag is raised. Samples are then dropped until software acknowledges the waiting buffer, and capture resumes at that buffer's start. A level interrupt reports each full flag whose interrupt enable is set. A plain sample-valid input stands in for the serial receiver. A registered write-valid, address and data output stands in for the memory port.

Top module: `pingpong_capture`

## Requirements
- R1: After reset, no write strobe is issued, irq is 0, and every register reads 0.
- R2: No sample is accepted while the enable bit (CTRL, address 0, bit 0) is 0. The first sample accepted after enabling is written at base 1 (address 2) with offset 0.
- R3: Each accepted sample shows up on the memory port one cycle later with the same data, at base plus byte offset. The offset then grows by 4.
- R4: When the byte offset after a sample reaches the size register (address 4), that buffer's full flag is set (STATUS address 1: bit 0 for buffer 1, bit 1 for buffer 2). The very next sample goes to offset 0 of the other buffer (base 2 at address 3).
- R5: irq is a level equal to (full1 AND CTRL bit 1) OR (full2 AND CTRL bit 2).
- R6: Writing 1 to STATUS bit 0 (or bit 1) clears that buffer's full flag at the next clock edge, and with it the irq request it caused.
- R7: If a buffer completes while the other buffer's full flag is set, the overrun flag (STATUS bit 2) is set. Samples are dropped until that buffer is acknowledged, and capture then resumes at its offset 0.
- R8: Buffer acknowledges never clear the overrun flag. Only writing 1 to STATUS bit 2 clears it.
- R9: The six low bits of the base and size registers read 0 whatever is written. CTRL bits above 2, STATUS bits above 2, and every unmapped address (5 to 7) also read 0.
- R10: Clearing the enable bit stops acceptance from the next cycle and returns the fill pointer to offset 0 of buffer 1. The base, size and flag registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| smp_valid | input | 1 | Incoming sample present this cycle |
| smp_data | input | 32 | Incoming sample |
| mem_wvalid | output | 1 | Memory write strobe |
| mem_waddr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Level interrupt request |

## Verification
The main function is driven as a table of sample bursts, each burst preceded by optional acknowledges. Some bursts stop one sample short of a buffer end, some finish a buffer exactly, some cross into the other buffer, and one acknowledges too late. These patterns separate an off-by-one full test, a gap or a repeated address at the switch, and an overrun raised on a buffer that was acknowledged in time. Directed tests then show that samples are dropped during overrun and that capture resumes at the start of the buffer. They also cover the stickiness of the overrun flag, the masking of the low address bits, and that disabling resets the pointer while keeping the registers. A last test shows that irq follows the interrupt enable as a level.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int REG_AW = 3;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t RA_CTRL  = 3'd0;
  localparam reg_addr_t RA_STAT  = 3'd1;
  localparam reg_addr_t RA_BASE1 = 3'd2;
  localparam reg_addr_t RA_BASE2 = 3'd3;
  localparam reg_addr_t RA_SIZE  = 3'd4;

  localparam int B_EN  = 0;
  localparam int B_IE1 = 1;
  localparam int B_IE2 = 2;
  localparam int B_F1  = 0;
  localparam int B_F2  = 1;
  localparam int B_OVR = 2;
endpackage

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  reg_addr_t         addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              en_o,
  output logic [ADDR_W-1:0] base1_o,
  output logic [ADDR_W-1:0] base2_o,
  output logic [ADDR_W-1:0] size_o,
  output logic              full1_o,
  output logic              full2_o,
  output logic              irq_o,
  input  logic              done_i,
  input  logic              done_buf_i
);
  localparam logic [ADDR_W-1:0] AMASK = {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [2:0]        ctrl_q, ctrl_n;
  logic [ADDR_W-1:0] b1_q, b1_n, b2_q, b2_n, sz_q, sz_n;
  logic              f1_q, f1_n, f2_q, f2_n, ovr_q, ovr_n;
  logic              ack1, ack2, ack_ovr, set1, set2, set_ovr;

  always_comb begin
    ack1    = we_i && addr_i == RA_STAT && wdata_i[B_F1];
    ack2    = we_i && addr_i == RA_STAT && wdata_i[B_F2];
    ack_ovr = we_i && addr_i == RA_STAT && wdata_i[B_OVR];
    set1    = done_i && !done_buf_i;
    set2    = done_i &&  done_buf_i;
    // a buffer finishes while the other one is still waiting for software
    set_ovr = (set1 && f2_q && !ack2) || (set2 && f1_q && !ack1);

    ctrl_n = ctrl_q;
    b1_n   = b1_q;
    b2_n   = b2_q;
    sz_n   = sz_q;
    if (we_i) begin
      case (addr_i)
        RA_CTRL:  ctrl_n = wdata_i[2:0];
        RA_BASE1: b1_n   = wdata_i[ADDR_W-1:0] & AMASK;
        RA_BASE2: b2_n   = wdata_i[ADDR_W-1:0] & AMASK;
        RA_SIZE:  sz_n   = wdata_i[ADDR_W-1:0] & AMASK;
        default: ;
      endcase
    end
    f1_n  = set1 ? 1'b1 : (ack1 ? 1'b0 : f1_q);
    f2_n  = set2 ? 1'b1 : (ack2 ? 1'b0 : f2_q);
    ovr_n = set_ovr ? 1'b1 : (ack_ovr ? 1'b0 : ovr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
      sz_q   <= '0;
      f1_q   <= 1'b0;
      f2_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      b1_q   <= b1_n;
      b2_q   <= b2_n;
      sz_q   <= sz_n;
      f1_q   <= f1_n;
      f2_q   <= f2_n;
      ovr_q  <= ovr_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL:  rdata_o[2:0] = ctrl_q;
      RA_STAT:  rdata_o[2:0] = {ovr_q, f2_q, f1_q};
      RA_BASE1: rdata_o[ADDR_W-1:0] = b1_q;
      RA_BASE2: rdata_o[ADDR_W-1:0] = b2_q;
      RA_SIZE:  rdata_o[ADDR_W-1:0] = sz_q;
      default: ;
    endcase
  end

  assign en_o    = ctrl_q[B_EN];
  assign base1_o = b1_q;
  assign base2_o = b2_q;
  assign size_o  = sz_q;
  assign full1_o = f1_q;
  assign full2_o = f2_q;
  assign irq_o   = (f1_q && ctrl_q[B_IE1]) || (f2_q && ctrl_q[B_IE2]);

  // R6: an acknowledge with no competing completion drops the flag
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack1 && !set1) |=> !f1_q);
  // R8: the overrun flag survives everything except its own clear bit
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ack_ovr) |=> ovr_q);
  // R4: a completion always leaves its flag set
  assert_full_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set2 |=> f2_q);
endmodule

// File: rtl/pp_fill.sv
module pp_fill #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base1_i,
  input  logic [ADDR_W-1:0] base2_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic              full1_i,
  input  logic              full2_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic              done_o,
  output logic              done_buf_o,
  output logic              wvalid_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int BPS = DATA_W / 8;

  logic [ADDR_W-1:0] off_q, off_n, off_inc;
  logic              cur_q, cur_n;
  logic              acc, last, cur_full;
  logic              wv_n;
  logic [ADDR_W-1:0] wa_n;

  always_comb begin
    cur_full = cur_q ? full2_i : full1_i;
    acc      = en_i && smp_valid_i && !cur_full;
    off_inc  = off_q + ADDR_W'(BPS);
    last     = acc && (off_inc >= size_i);
    off_n    = off_q;
    cur_n    = cur_q;
    if (!en_i) begin
      off_n = '0;
      cur_n = 1'b0;
    end else if (acc) begin
      if (last) begin
        off_n = '0;
        cur_n = !cur_q;
      end else begin
        off_n = off_inc;
      end
    end
    wv_n = acc;
    wa_n = (cur_q ? base2_i : base1_i) + off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q    <= '0;
      cur_q    <= 1'b0;
      wvalid_o <= 1'b0;
      waddr_o  <= '0;
      wdata_o  <= '0;
    end else begin
      off_q    <= off_n;
      cur_q    <= cur_n;
      wvalid_o <= wv_n;
      if (acc) begin
        waddr_o <= wa_n;
        wdata_o <= smp_data_i;
      end
    end
  end

  assign done_o     = last;
  assign done_buf_o = cur_q;

  // R3: an accepted sample appears one cycle later with its data
  assert_sample_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (wvalid_o && wdata_o == $past(smp_data_i)));
  // R10: no strobe follows a cycle with capture disabled
  assert_disable_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !wvalid_o);
  // R7: a pending full buffer is never written
  assert_drop_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_q && full1_i) |=> !wvalid_o);
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture
  import pp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        smp_valid,
  input  logic [31:0] smp_data,
  output logic        mem_wvalid,
  output logic [31:0] mem_waddr,
  output logic [31:0] mem_wdata,
  output logic        irq
);
  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic              en, full1, full2, done, done_buf;
  logic [ADDR_W-1:0] base1, base2, size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  pp_regs #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .en_o(en), .base1_o(base1), .base2_o(base2), .size_o(size),
    .full1_o(full1), .full2_o(full2), .irq_o(irq),
    .done_i(done), .done_buf_i(done_buf)
  );

  pp_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fill (
    .clk(clk), .rst_n(rst_i_n),
    .en_i(en), .base1_i(base1), .base2_i(base2), .size_i(size),
    .full1_i(full1), .full2_i(full2),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .done_o(done), .done_buf_o(done_buf),
    .wvalid_o(mem_wvalid), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
  );

  // R5: a raised request always traces back to a full flag
  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> (full1 || full2));
  // R2: a strobe needs capture enabled one cycle earlier
  assert_strobe_en_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_wvalid |-> $past(en && smp_valid));
endmodule

// File: tb/sim_pingpong_capture.sv
module sim_pingpong_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        smp_valid;
  logic [31:0] smp_data;
  logic        mem_wvalid, irq;
  logic [31:0] mem_waddr, mem_wdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pingpong_capture u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .mem_wvalid(mem_wvalid), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  // vector: {ack[2:0], count[7:0], last address[31:0], status[2:0]}
  localparam int NV = 7;
  localparam logic [45:0] VEC [0:NV-1] = '{
    {3'd0, 8'd15, 32'h0000_1038, 3'd0},
    {3'd0, 8'd1,  32'h0000_103C, 3'd1},
    {3'd0, 8'd4,  32'h0000_200C, 3'd1},
    {3'd1, 8'd12, 32'h0000_203C, 3'd2},
    {3'd0, 8'd3,  32'h0000_1008, 3'd2},
    {3'd2, 8'd13, 32'h0000_103C, 3'd1},
    {3'd0, 8'd16, 32'h0000_203C, 3'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] d, output logic v, output logic [31:0] a,
                      output logic [31:0] q);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
    v = mem_wvalid; a = mem_waddr; q = mem_wdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic v;
    logic [31:0] a, q, r;
    int strobes, bad_data;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    smp_valid = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd0, r); chk("R1 ctrl", r, 0);
    rd(3'd1, r); chk("R1 status", r, 0);
    rd(3'd4, r); chk("R1 size", r, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 strobe", {31'd0, mem_wvalid}, 0);

    wr(3'd2, 32'h1000); wr(3'd3, 32'h2000); wr(3'd4, 32'h40);
    // R2 nothing accepted while disabled
    send(32'hAAAA, v, a, q); chk("R2 disabled drop", {31'd0, v}, 0);
    wr(3'd0, 32'h7);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  ack, est;
      logic [7:0]  n;
      logic [31:0] ea, la;
      {ack, n, ea, est} = VEC[i];
      if (ack != 0) wr(3'd1, {29'd0, ack});
      strobes = 0; bad_data = 0; la = '0;
      for (int k = 0; k < int'(n); k++) begin
        send(32'hC000_0000 + 32'(i * 256 + k), v, a, q);
        if (v) begin
          strobes++;
          la = a;
          if (q !== 32'hC000_0000 + 32'(i * 256 + k)) bad_data++;
        end
      end
      chk("R3 strobe count", 32'(strobes), 32'(n));
      chk("R3 data", 32'(bad_data), 0);
      chk("R4 last address", la, ea);
      rd(3'd1, r); chk("R4/R7 status", r, {29'd0, est});
      chk("R5 irq level", {31'd0, irq}, {31'd0, |est[1:0]});
    end

    // R7 drop during overrun
    send(32'h5555, v, a, q); chk("R7 drop while pending", {31'd0, v}, 0);
    rd(3'd1, r); chk("R7 status held", r, 7);
    // R8 ack1 leaves overrun; R6 clears full1
    wr(3'd1, 32'h1);
    rd(3'd1, r); chk("R8 ack1 keeps overrun", r, 6);
    chk("R5 irq from full2", {31'd0, irq}, 1);
    send(32'h6666, v, a, q); chk("R7 resume at start", a, 32'h1000);
    chk("R7 resume strobe", {31'd0, v}, 1);
    wr(3'd1, 32'h2);
    rd(3'd1, r); chk("R8 ack2 keeps overrun", r, 4);
    chk("R6 irq dropped", {31'd0, irq}, 0);
    wr(3'd1, 32'h4);
    rd(3'd1, r); chk("R8 overrun clear", r, 0);

    // R9 masking and reserved bits
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, r); chk("R9 base low bits", r, 32'hFFFF_FFC0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, r); chk("R9 ctrl reserved", r, 7);
    rd(3'd7, r); chk("R9 unmapped", r, 0);
    wr(3'd2, 32'h1000);

    // R10 disable resets pointer, keeps registers
    wr(3'd0, 32'h6);
    send(32'h7777, v, a, q); chk("R10 no accept", {31'd0, v}, 0);
    rd(3'd3, r); chk("R10 base2 kept", r, 32'h2000);
    rd(3'd4, r); chk("R10 size kept", r, 32'h40);
    wr(3'd0, 32'h7);
    send(32'h8888, v, a, q); chk("R10 restart address", a, 32'h1000);

    // R5 interrupt enable gating
    wr(3'd0, 32'h1);
    for (int k = 0; k < 15; k++) send(32'(k), v, a, q);
    rd(3'd1, r); chk("R4 full1 set", r, 1);
    chk("R5 irq masked", {31'd0, irq}, 0);
    wr(3'd0, 32'h3);
    chk("R5 irq enabled", {31'd0, irq}, 1);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd1, r); chk("R1 status after reset", r, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);

    finish_run();
  end
endmodule